// File: doc/BRIEF.md
# Under-Voltage Lockout Permission Controller

This block decides, cycle by cycle, whether a gate driver may switch. A sampled bias-rail code is compared against two programmable codes: a higher enable level and a lower trip level. The gap between them forms a digital hysteresis window, so ripple near one boundary cannot toggle the permission. Before the rail can enable the output it must pass a qualification period and an optional start delay. A dip has to persist for a debounce interval before it counts as a trip. After a trip, a hold-off period keeps the output disabled even if the rail comes back at once.

After a trip the controller either waits for an explicit clear or a drop-and-raise of the enable input (latch policy), or it re-qualifies on its own (auto-retry policy). The re-enable level after a fault can optionally be raised to a separate recovery code. An active-low ready flag marks that the block is qualified to drive. An active-low fault flag marks trips, either as a one-cycle pulse or as a level held until cleared. All timers count clock cycles.

Top module: `uvlo_permit_fsm`

## Requirements
- R1: While reset is held and on release, out_en is 0, rdy_n is 1 and flt_n is 1.
- R2: From the idle state with the rail strictly above von_code, out_en rises on the qual_cycles+start_cycles+3rd rising edge counted from the first edge that samples en=1. rdy_n is low exactly when out_en is high.
- R3: During qualification, a rail sample not strictly above the enable level clears the qualify count, and the full qual_cycles count starts again.
- R4: During the start delay, a rail sample below voff_code sends the machine back to the start of qualification and does not lower flt_n.
- R5: While enabled, a trip happens on the deb_cycles+1th consecutive rail sample below voff_code. out_en falls on that edge. A shorter run of low samples has no effect.
- R6: In auto-retry mode (latch_mode=0), out_en stays 0 after a trip through hold_cycles+1 edges in the fault state, one edge in the recover state and a fresh qualification. With the rail high, it rises hold_cycles+qual_cycles+start_cycles+4 edges after the trip edge.
- R7: In latch mode (latch_mode=1), a trip keeps out_en at 0 until latch_clr is sampled high after hold-off or en is sampled low. A clear pulse leads to out_en rising qual_cycles+start_cycles+4 edges after the clear edge.
- R8: en=0 removes permission on the next edge. With en=1, out_en never rises while the rail is below voff_code or not above von_code.
- R9: With flt_pulse_mode=1, flt_n is low for exactly the one cycle in which out_en first reads 0 after a trip. With flt_pulse_mode=0, flt_n goes low at that same point and stays low until latch_clr is sampled high.
- R10: With vrec_en=1, after a trip the enable level is vrec_code instead of von_code until out_en next rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_code | input | CODE_W | Sampled bias-rail code |
| von_code | input | CODE_W | Enable level (must exceed voff_code) |
| voff_code | input | CODE_W | Trip level |
| vrec_code | input | CODE_W | Post-fault enable level (at or above von_code) |
| vrec_en | input | 1 | Use vrec_code after a fault |
| en | input | 1 | Controller-level permission |
| latch_mode | input | 1 | 1 latch after trip, 0 auto-retry |
| latch_clr | input | 1 | Clears a latched trip and the held fault flag |
| flt_pulse_mode | input | 1 | 1 one-cycle fault pulse, 0 held fault level |
| qual_cycles | input | TMR_W | Qualification length in cycles |
| start_cycles | input | TMR_W | Start delay in cycles |
| hold_cycles | input | TMR_W | Post-trip hold-off in cycles |
| deb_cycles | input | TMR_W | Extra trip debounce samples |
| out_en | output | 1 | Gate output permission |
| rdy_n | output | 1 | Low when qualified to drive |
| flt_n | output | 1 | Low on a trip event |

## Verification
The assertions take for granted that von_code is above voff_code. They also assume that flt_pulse_mode does not change in the cycle around a fault-flag edge. Without the first, the check that the rail was at or above the trip level when permission rose would be meaningless. Without the second, flipping the mode could lower flt_n with no trip. The stimulus keeps the threshold codes fixed at 600, 500 and 700, and moves the rail only among levels that sit clearly on one side of each threshold. It changes flt_pulse_mode only while no fault flag is pending.

// File: rtl/uvlo_permit_fsm.sv
module uvlo_permit_fsm #(
  parameter int CODE_W = 10,
  parameter int TMR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rail_code,
  input  logic [CODE_W-1:0] von_code,
  input  logic [CODE_W-1:0] voff_code,
  input  logic [CODE_W-1:0] vrec_code,
  input  logic              vrec_en,
  input  logic              en,
  input  logic              latch_mode,
  input  logic              latch_clr,
  input  logic              flt_pulse_mode,
  input  logic [TMR_W-1:0]  qual_cycles,
  input  logic [TMR_W-1:0]  start_cycles,
  input  logic [TMR_W-1:0]  hold_cycles,
  input  logic [TMR_W-1:0]  deb_cycles,
  output logic              out_en,
  output logic              rdy_n,
  output logic              flt_n
);
  typedef enum logic [2:0] {S_OFF, S_ARM, S_ON, S_FAULT, S_REC} st_t;

  st_t              st;
  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] dcnt;
  logic             start_ph;
  logic             use_rec;
  logic             flt_lvl;
  logic             trip_q;

  logic [CODE_W-1:0] thr_on;
  logic              above_on;
  logic              below_off;
  logic              trip;

  assign thr_on    = (vrec_en && use_rec) ? vrec_code : von_code;
  assign above_on  = rail_code > thr_on;
  assign below_off = rail_code < voff_code;
  assign trip      = (st == S_ON) && en && below_off && (dcnt >= deb_cycles);

  assign out_en = (st == S_ON);
  assign rdy_n  = ~out_en;
  assign flt_n  = flt_pulse_mode ? ~trip_q : ~flt_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      cnt      <= '0;
      dcnt     <= '0;
      start_ph <= 1'b0;
      use_rec  <= 1'b0;
      flt_lvl  <= 1'b0;
      trip_q   <= 1'b0;
    end else begin
      trip_q <= trip;
      if (trip)           flt_lvl <= 1'b1;
      else if (latch_clr) flt_lvl <= 1'b0;

      case (st)
        S_OFF: begin
          cnt      <= '0;
          dcnt     <= '0;
          start_ph <= 1'b0;
          if (en) st <= S_ARM;
        end
        S_ARM: begin
          if (!en) begin
            st       <= S_OFF;
            cnt      <= '0;
            start_ph <= 1'b0;
          end else if (!start_ph) begin
            if (!above_on)               cnt <= '0;
            else if (cnt >= qual_cycles) begin
              start_ph <= 1'b1;
              cnt      <= '0;
            end else                     cnt <= cnt + 1'b1;
          end else begin
            if (below_off) begin
              start_ph <= 1'b0;
              cnt      <= '0;
            end else if (cnt >= start_cycles) begin
              st       <= S_ON;
              cnt      <= '0;
              dcnt     <= '0;
              start_ph <= 1'b0;
              use_rec  <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_ON: begin
          if (!en) begin
            st   <= S_OFF;
            dcnt <= '0;
          end else if (trip) begin
            st      <= S_FAULT;
            cnt     <= '0;
            dcnt    <= '0;
            use_rec <= 1'b1;
          end else if (below_off) begin
            dcnt <= dcnt + 1'b1;
          end else begin
            dcnt <= '0;
          end
        end
        S_FAULT: begin
          if (cnt < hold_cycles) begin
            cnt <= cnt + 1'b1;
          end else if (!latch_mode) begin
            st  <= S_REC;
            cnt <= '0;
          end else if (latch_clr || !en) begin
            st  <= S_OFF;
            cnt <= '0;
          end
        end
        S_REC: begin
          cnt      <= '0;
          start_ph <= 1'b0;
          st       <= en ? S_ARM : S_OFF;
        end
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/uvlo_permit_chk.sv
module uvlo_permit_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] rail_code,
  input logic [CODE_W-1:0] voff_code,
  input logic              en,
  input logic              flt_pulse_mode,
  input logic              out_en,
  input logic              flt_n
);
  // R8
  en_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(en));

  // R8
  rail_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> ($past(rail_code) >= $past(voff_code)));

  // R5
  drop_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en) |-> (!$past(en) || ($past(rail_code) < $past(voff_code))));

  // R9
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_pulse_mode && !flt_n) |=> (flt_n || !flt_pulse_mode));

  // R9
  fault_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flt_n) && $stable(flt_pulse_mode)) |-> !out_en);
endmodule

bind uvlo_permit_fsm uvlo_permit_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rail_code(rail_code), .voff_code(voff_code),
  .en(en), .flt_pulse_mode(flt_pulse_mode), .out_en(out_en), .flt_n(flt_n)
);

// File: tb/uvlo_permit_fsm_tb_top.sv
`timescale 1ns/1ps
module uvlo_permit_fsm_tb_top;
  localparam int CODE_W = 10;
  localparam int TMR_W  = 12;
  localparam int HI = 800, MID = 550, LO = 400, VR_MID = 650;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CODE_W-1:0] rail_code = '0;
  logic [CODE_W-1:0] von_code = 10'd600, voff_code = 10'd500, vrec_code = 10'd700;
  logic vrec_en = 1'b0, en = 1'b0, latch_mode = 1'b0, latch_clr = 1'b0, flt_pulse_mode = 1'b1;
  logic [TMR_W-1:0] qual_cycles = '0, start_cycles = '0, hold_cycles = '0, deb_cycles = '0;
  logic out_en, rdy_n, flt_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  uvlo_permit_fsm #(.CODE_W(CODE_W), .TMR_W(TMR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rail_code(rail_code), .von_code(von_code),
    .voff_code(voff_code), .vrec_code(vrec_code), .vrec_en(vrec_en), .en(en),
    .latch_mode(latch_mode), .latch_clr(latch_clr), .flt_pulse_mode(flt_pulse_mode),
    .qual_cycles(qual_cycles), .start_cycles(start_cycles), .hold_cycles(hold_cycles),
    .deb_cycles(deb_cycles), .out_en(out_en), .rdy_n(rdy_n), .flt_n(flt_n)
  );

  // qual, start, expected enable latency
  localparam int VEC [6][3] = '{
    '{0, 0, 3}, '{1, 0, 4}, '{3, 2, 8}, '{0, 5, 8}, '{7, 1, 11}, '{10, 10, 23}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!out_en && n < 500) begin
      tick();
      n++;
    end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (out_en && n < 500) begin
      tick();
      n++;
    end
  endtask

  task automatic do_reset();
    en = 1'b0;
    latch_clr = 1'b0;
    rail_code = HI;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic reach_on(int q, int s, int h, int d);
    int n;
    do_reset();
    qual_cycles = q[TMR_W-1:0];
    start_cycles = s[TMR_W-1:0];
    hold_cycles = h[TMR_W-1:0];
    deb_cycles = d[TMR_W-1:0];
    en = 1'b1;
    wait_rise(n);
  endtask

  initial begin
    int n;
    int min_flt;

    // R1 reset state
    rst_n = 1'b0;
    tick(2);
    chk("R1 out_en in reset", out_en, 0);
    chk("R1 rdy_n in reset", rdy_n, 1);
    chk("R1 flt_n in reset", flt_n, 1);
    rst_n = 1'b1;
    tick();
    chk("R1 out_en after release", out_en, 0);

    // R2 enable latency table
    for (int v = 0; v < 6; v++) begin
      do_reset();
      qual_cycles = VEC[v][0][TMR_W-1:0];
      start_cycles = VEC[v][1][TMR_W-1:0];
      en = 1'b1;
      wait_rise(n);
      chk($sformatf("R2 latency q=%0d s=%0d", VEC[v][0], VEC[v][1]), n, VEC[v][2]);
      chk("R2 rdy_n with out_en", rdy_n, 0);
    end

    // R3 qualification restarts on a dip below the enable level
    do_reset();
    qual_cycles = 5; start_cycles = 0;
    en = 1'b1;
    tick(4);
    rail_code = MID;
    tick();
    rail_code = HI;
    wait_rise(n);
    chk("R3 restart latency", n, 7);

    // R4 dip during start delay returns to qualification, no fault
    do_reset();
    qual_cycles = 2; start_cycles = 6; flt_pulse_mode = 1'b1;
    en = 1'b1;
    tick(5);
    rail_code = LO;
    tick();
    min_flt = flt_n;
    rail_code = HI;
    n = 0;
    while (!out_en && n < 500) begin
      tick();
      n++;
      if (flt_n < min_flt) min_flt = flt_n;
    end
    chk("R4 restart latency", n, 10);
    chk("R4 no fault flag", min_flt, 1);

    // R5 debounce: short dip ignored, long dip trips
    reach_on(1, 0, 4, 3);
    rail_code = LO;
    tick(3);
    rail_code = HI;
    tick();
    chk("R5 short dip ignored", out_en, 1);
    rail_code = LO;
    wait_fall(n);
    chk("R5 trip latency", n, 4);
    // R9 pulse flag coincides with out_en drop, then releases
    chk("R9 pulse low at trip", flt_n, 0);
    rail_code = HI;
    tick();
    chk("R9 pulse released", flt_n, 1);

    // R6 auto-retry with hold-off
    reach_on(2, 1, 5, 1);
    latch_mode = 1'b0;
    rail_code = LO;
    wait_fall(n);
    chk("R6 trip latency", n, 2);
    rail_code = HI;
    wait_rise(n);
    chk("R6 retry latency", n, 12);

    // R7 latch mode, clear pulse
    latch_mode = 1'b1;
    reach_on(2, 1, 3, 0);
    rail_code = LO;
    wait_fall(n);
    rail_code = HI;
    tick(40);
    chk("R7 latched stays off", out_en, 0);
    latch_clr = 1'b1;
    wait_rise(n);
    latch_clr = 1'b0;
    chk("R7 clear latency", n, 7);

    // R7 latch mode, en re-handshake
    rail_code = LO;
    wait_fall(n);
    rail_code = HI;
    tick(20);
    chk("R7 latched stays off again", out_en, 0);
    en = 1'b0;
    tick(6);
    en = 1'b1;
    wait_rise(n);
    chk("R7 handshake latency", n, 6);
    latch_mode = 1'b0;

    // R8 rail and en dominance
    do_reset();
    qual_cycles = 0; start_cycles = 0;
    rail_code = LO;
    en = 1'b1;
    tick(30);
    chk("R8 rail below trip level", out_en, 0);
    rail_code = MID;
    tick(30);
    chk("R8 rail inside window", out_en, 0);
    rail_code = HI;
    wait_rise(n);
    chk("R8 enables once high", out_en, 1);
    en = 1'b0;
    tick();
    chk("R8 en removes permission", out_en, 0);

    // R9 level fault flag
    flt_pulse_mode = 1'b0;
    reach_on(1, 0, 2, 0);
    rail_code = LO;
    wait_fall(n);
    chk("R9 level low at trip", flt_n, 0);
    rail_code = HI;
    wait_rise(n);
    tick(5);
    chk("R9 level held after retry", flt_n, 0);
    latch_clr = 1'b1;
    tick();
    latch_clr = 1'b0;
    chk("R9 level cleared", flt_n, 1);
    flt_pulse_mode = 1'b1;

    // R10 recovery level after a fault
    vrec_en = 1'b1;
    reach_on(2, 1, 3, 0);
    rail_code = LO;
    wait_fall(n);
    rail_code = VR_MID;
    tick(40);
    chk("R10 held below recovery level", out_en, 0);
    rail_code = HI;
    wait_rise(n);
    chk("R10 latency above recovery level", n, 5);
    vrec_en = 1'b0;

    summary();
  end
endmodule